// File: doc/BRIEF.md
# Mirrored Two-Read Integer Register File

This block is the integer register file of a small RISC-style core. It holds thirty-two 32-bit registers, addressed by a 5-bit register number. In every clock cycle it serves two source-operand reads and accepts one result write. Register 0 always reads as zero.

The target storage is a block memory with a single read port. One such array cannot return two operands in the same cycle, so the block keeps two identical copies. Copy 0 answers read port 1 and copy 1 answers read port 2. Every write lands at the same address in both copies in the same cycle, which keeps the copies equal.

Reads are registered: an address presented in one cycle yields its data in the next. A write and a read of the same non-zero register in the same cycle return the newly written value. Each port has its own bypass for this. Reset clears only the output-side registers; the stored contents survive it.

Top module: `mirrored_regfile`

## Requirements
- R1: The block holds 32 registers of 32 bits each, indexed by a 5-bit number. Data for a read address presented at one rising edge appears on that port's data output after that edge and holds until the next edge.
- R2: A read of index 0 on either port returns 0, including after a write to index 0. A write to index 0 changes no register.
- R3: A write (`wr_en`=1) stores `wr_data` at `wr_addr` in both copies, so either read port later returns that value for that address.
- R4: The two read ports take independent addresses in the same cycle, and each returns the contents of its own address. When the two addresses are equal, both ports return equal data.
- R5: When read port 1 and an enabled write target the same non-zero index in the same cycle, port 1 returns the data being written.
- R6: The same-cycle bypass of R5 applies to read port 2 on its own, whatever port 1 is addressing.
- R7: While `rst_n` is low, both data outputs are 0. Register contents written before reset are still returned after reset.
- R8: With `wr_en`=0, `wr_addr` and `wr_data` have no effect on any register.
- R9: At most one register is written per cycle. Back-to-back writes to one index leave the later value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| rd1_addr | input | 5 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 data, one cycle after the address |
| rd2_addr | input | 5 | Read port 2 register index |
| rd2_data | output | 32 | Read port 2 data, one cycle after the address |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write data |

## Verification
The bound checker watches several rules on every cycle: the zero reads of index 0, the same-cycle bypass on each port, the zeroed outputs during reset, and the equality of the two ports whenever both read the same already-written index. That last rule is evidence that the copies stay identical. Only the bench's scenarios can show that the stored values are correct. The bench fills every register, sweeps every address pair, issues random collisions, drops disabled writes and checks that contents survive a reset, and it compares each result against its own reference array.

// File: rtl/mirrored_regfile.sv
module mirrored_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  input  logic [ADDR_W-1:0] rd2_addr,
  output logic [DATA_W-1:0] rd2_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int COPIES = 2;
  localparam logic [1:0] SEL_MEM  = 2'd0;
  localparam logic [1:0] SEL_BYP  = 2'd1;
  localparam logic [1:0] SEL_ZERO = 2'd2;

  logic              wr_live;
  logic [DATA_W-1:0] port_out [COPIES];

  assign wr_live = wr_en && (wr_addr != '0);

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] ra;
    logic [DATA_W-1:0] q, byp;
    logic [1:0]        sel;

    assign ra = (c == 0) ? rd1_addr : rd2_addr;

    always_ff @(posedge clk)
      if (wr_live) mem[wr_addr] <= wr_data;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        q   <= '0;
        byp <= '0;
        sel <= SEL_ZERO;
      end else begin
        q   <= mem[ra];
        byp <= wr_data;
        if (ra == '0)                      sel <= SEL_ZERO;
        else if (wr_live && wr_addr == ra) sel <= SEL_BYP;
        else                               sel <= SEL_MEM;
      end

    assign port_out[c] = (sel == SEL_ZERO) ? '0 :
                         (sel == SEL_BYP)  ? byp : q;
  end

  assign rd1_data = port_out[0];
  assign rd2_data = port_out[1];
endmodule

module mirrored_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd1_addr,
  input logic [DATA_W-1:0] rd1_data,
  input logic [ADDR_W-1:0] rd2_addr,
  input logic [DATA_W-1:0] rd2_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DEPTH-1:0] seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else if (wr_en) seen[wr_addr] <= 1'b1;

  assert_zero_port1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_addr == '0) |=> (rd1_data == '0));
  assert_zero_port2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd2_addr == '0) |=> (rd2_data == '0));
  assert_bypass_port1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd1_addr == wr_addr) |=> (rd1_data == $past(wr_data)));
  assert_bypass_port2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd2_addr == wr_addr) |=> (rd2_data == $past(wr_data)));
  assert_copies_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_addr == rd2_addr && seen[rd1_addr]) |=> (rd1_data == rd2_data));
  assert_reset_zero_R7: assert property (@(posedge clk)
    !rst_n |=> (rd1_data == '0 && rd2_data == '0));
endmodule

bind mirrored_regfile mirrored_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .rd1_addr(rd1_addr), .rd1_data(rd1_data),
  .rd2_addr(rd2_addr), .rd2_data(rd2_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/mirrored_regfile_tb.sv
`timescale 1ns/1ps
module mirrored_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd1_addr = '0, rd2_addr = '0, wr_addr = '0;
  logic [31:0] rd1_data, rd2_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] ref_mem [32];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mirrored_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .rd2_addr(rd2_addr), .rd2_data(rd2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] pat(input int i, input int s);
    return (i * 32'h0101_0101) ^ (s * 32'h1357_9BDF) ^ 32'hA500_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_rd(input logic [4:0] a);
    if (a == 0) return 32'd0;
    if (wr_en && wr_addr == a) return wr_data;
    return ref_mem[a];
  endfunction

  function automatic string tag(input logic [4:0] a, input int port, input string dflt);
    if (a == 0) return "R2";
    if (wr_en && wr_addr == a) return port == 1 ? "R5" : "R6";
    return dflt;
  endfunction

  task automatic step(input logic [4:0] a1, input logic [4:0] a2, input logic we,
                      input logic [4:0] wa, input logic [31:0] wd, input string dflt);
    logic [31:0] e1, e2;
    string t1, t2;
    @(negedge clk);
    rd1_addr = a1; rd2_addr = a2; wr_en = we; wr_addr = wa; wr_data = wd;
    e1 = expect_rd(a1); e2 = expect_rd(a2);
    t1 = tag(a1, 1, dflt); t2 = tag(a2, 2, dflt);
    if (we && wa != 0) ref_mem[wa] = wd;
    @(posedge clk); #1;
    check(t1, rd1_data, e1);
    check(t2, rd2_data, e2);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7", rd1_data, 32'd0);
    check("R7", rd2_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 1; i < 32; i++) step(5'(i), 5'(32 - i), 1'b1, 5'(i), pat(i, 0), "R3");
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++) step(5'(a), 5'(b), 1'b0, 5'(a), 32'hDEAD_BEEF, "R4");

    step(5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, "R2");
    step(5'd0, 5'd0, 1'b0, 5'd0, 32'd0, "R2");

    step(5'd7, 5'd7, 1'b0, 5'd7, 32'h1234_5678, "R8");
    step(5'd7, 5'd7, 1'b0, 5'd0, 32'd0, "R8");

    step(5'd3, 5'd9, 1'b1, 5'd9, 32'h0000_0099, "R1");
    step(5'd9, 5'd3, 1'b1, 5'd9, 32'h0000_0AAA, "R9");
    step(5'd9, 5'd9, 1'b0, 5'd0, 32'd0, "R9");

    for (int n = 0; n < 4000; n++) begin
      logic [4:0] a1, a2, wa;
      logic [1:0] mode;
      a1 = 5'($urandom); a2 = 5'($urandom); wa = 5'($urandom); mode = 2'($urandom);
      if (mode == 1) wa = a1;
      if (mode == 2) wa = a2;
      step(a1, a2, 1'($urandom), wa, $urandom, "R4");
    end

    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(posedge clk); #1;
    check("R7", rd1_data, 32'd0);
    check("R7", rd2_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 32; i++) step(5'(i), 5'(31 - i), 1'b0, 5'd0, 32'd0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule